// File: doc/BRIEF.md
# Legacy Memory Attribute and SMRAM Decoder

This block routes each access that falls in the legacy upper-memory hole, 0xA0000 up to 0xFFFFF, either to system DRAM or out to the expansion bus. The choice depends on the address, on whether the access is a read or a write, and on a system-management-mode flag from the processor side. It raises one of two single-cycle strobes, `dram_sel` or `bus_fwd`, one clock after the access is presented.

The routing is programmed through a byte-wide configuration write port. The region above 0xC0000 is governed by two-bit attribute fields. There is one field for the top 64 KB and one for each of twelve 16 KB segments, and the fields are packed two to a byte. The 128 KB video window at 0xA0000 is governed by an SMRAM control byte together with the management-mode flag. Addresses outside the hole raise neither strobe and are left to other decode logic.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset every attribute field is 0 and the SMRAM byte at offset 0x72 holds 0x02. As a result every in-range access is forwarded to the bus, and both strobes are low while reset is held.
- R2: The 64 KB range 0xF0000–0xFFFFF takes its attribute from bits [5:4] of the byte at offset 0x59.
- R3: The range 0xC0000–0xEFFFF is split into 16 KB segments i = 0..11, counted from 0xC0000. Segment i uses the byte at offset 0x5A + (i >> 1): bits [1:0] when i is even and bits [5:4] when i is odd.
- R4: Attribute encoding. With 3, reads and writes go to DRAM. With 1, reads go to DRAM and writes are forwarded to the bus. With 0 or 2, reads and writes are both forwarded to the bus.
- R5: An access in 0xA0000–0xBFFFF goes to DRAM when SMRAM bit 6 is 1, or when `smm_active` is 1 and SMRAM bit 3 is 1. Otherwise it is forwarded to the bus.
- R6: For every access presented with `acc_valid` and inside 0xA0000–0xFFFFF, exactly one of `dram_sel` and `bus_fwd` is high on the following cycle. Neither strobe is high in a cycle that does not follow a valid access.
- R7: Addresses below 0xA0000 or at or above 0x100000 raise neither strobe. This includes addresses whose low 20 bits lie in the hole.
- R8: Writes to offsets other than 0x59–0x5F and 0x72 change no routing. Bits [3:2] and [7:6] of an attribute byte have no effect on routing.
- R9: An access uses the configuration held before its own clock edge. A configuration write made in the same cycle takes effect from the next access onward. `smm_active` is taken in the same cycle as the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Physical address of the access |
| acc_write | input | 1 | 1 = write, 0 = read |
| smm_active | input | 1 | Processor is in system management mode |
| dram_sel | output | 1 | Access goes to DRAM (one cycle after the access) |
| bus_fwd | output | 1 | Access is forwarded to the expansion bus (one cycle after the access) |

## Verification
A configuration write and an access can land on the same clock edge. The question is then whether the access sees the old routing or the new one. The bench provokes this by issuing a write to the SMRAM byte together with a video-window read, and a write to a segment attribute byte together with a write access to that segment. In both cases it expects the old route on that access and the new route on the access that follows. The sweeps then probe every 16 KB page of the hole, with both access types and both management-mode states, under many programmed patterns. Every result is compared with the route the bench derives from its own copy of the written bytes.

// File: rtl/legacy_dec_pkg.sv
// Shared types and routing rules for the legacy memory decoder.
// Assumes 16 KB decode granularity and a 1 MB legacy address hole.
package legacy_dec_pkg;

    // Two-bit segment attribute codes; ATTR_ALT behaves like ATTR_OFF.
    typedef enum logic [1:0] {
        ATTR_OFF = 2'd0,
        ATTR_RO  = 2'd1,
        ATTR_ALT = 2'd2,
        ATTR_RW  = 2'd3
    } attr_t;

    // Exactly one of the two destinations is chosen for an in-range access.
    typedef struct packed {
        logic dram;
        logic bus;
    } route_t;

    localparam int PAGE_SHIFT = 14;   // 16 KB pages
    localparam int PAGE_W     = 6;    // pages within 1 MB
    localparam int HOLE_TOP   = 20;   // address bit where the 1 MB space ends
    localparam int WIN_FIRST  = 40;   // page of 0xA0000
    localparam int SEG_FIRST  = 48;   // page of 0xC0000
    localparam int HIGH_FIRST = 60;   // page of 0xF0000

    // Map an attribute and access direction to a destination.
    function automatic route_t attr_route(attr_t a, logic is_write);
        route_t r;
        logic   to_dram;
        if (is_write) to_dram = (a == ATTR_RW);
        else          to_dram = (a == ATTR_RO) || (a == ATTR_RW);
        r.dram = to_dram;
        r.bus  = !to_dram;
        return r;
    endfunction

endpackage

// File: rtl/legacy_cfg_regs.sv
// Configuration storage: the packed attribute bytes and the SMRAM control bits.
// Only the fields that drive routing are kept. Attribute byte k lives at
// ATTR_BASE + k; the SMRAM byte lives at SMRAM_OFS. Writes elsewhere are dropped.
module legacy_cfg_regs #(
    parameter int          N_SEG     = 12,
    parameter int          CFG_AW    = 8,
    parameter logic [7:0]  ATTR_BASE = 8'h59,
    parameter logic [7:0]  SMRAM_OFS = 8'h72,
    parameter logic [7:0]  SMRAM_RST = 8'h02,
    localparam int         N_REGS    = 1 + (N_SEG + 1) / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    output logic [N_REGS-1:0][1:0]      fld_lo,
    output logic [N_REGS-1:0][1:0]      fld_hi,
    output logic                        smram_open,
    output logic                        smram_smm_en
);

    genvar k;
    generate
        for (k = 0; k < N_REGS; k++) begin : g_attr
            localparam logic [CFG_AW-1:0] OFS = CFG_AW'(ATTR_BASE) + CFG_AW'(k);
            // Capture the two attribute fields of byte k on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fld_lo[k] <= 2'd0;
                    fld_hi[k] <= 2'd0;
                end else if (cfg_we && cfg_addr == OFS) begin
                    fld_lo[k] <= cfg_wdata[1:0];
                    fld_hi[k] <= cfg_wdata[5:4];
                end
            end
        end
    endgenerate

    // Capture the SMRAM open and management-mode enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smram_open   <= SMRAM_RST[6];
            smram_smm_en <= SMRAM_RST[3];
        end else if (cfg_we && cfg_addr == CFG_AW'(SMRAM_OFS)) begin
            smram_open   <= cfg_wdata[6];
            smram_smm_en <= cfg_wdata[3];
        end
    end

endmodule

// File: rtl/legacy_seg_map.sv
// Unpacks the attribute bytes into one attribute per decode range.
// Byte 0 supplies the top 64 KB from its high field. Segment i takes
// byte 1 + i/2, low field when i is even and high field when i is odd.
module legacy_seg_map
    import legacy_dec_pkg::*;
#(
    parameter int  N_SEG  = 12,
    localparam int N_REGS = 1 + (N_SEG + 1) / 2
) (
    input  logic [N_REGS-1:0][1:0]  fld_lo,
    input  logic [N_REGS-1:0][1:0]  fld_hi,
    output attr_t                   high_attr,
    output attr_t [N_SEG-1:0]       seg_attr
);

    // Top range uses the high field of the first byte.
    assign high_attr = attr_t'(fld_hi[0]);

    genvar i;
    generate
        for (i = 0; i < N_SEG; i++) begin : g_seg
            if ((i % 2) == 0) begin : g_even
                assign seg_attr[i] = attr_t'(fld_lo[1 + i / 2]);
            end else begin : g_odd
                assign seg_attr[i] = attr_t'(fld_hi[1 + i / 2]);
            end
        end
    endgenerate

    // The low field of byte 0 has no range assigned to it.
    logic spare_lo;
    assign spare_lo = ^fld_lo[0];

endmodule

// File: rtl/legacy_route.sv
// Combinational range decode and destination choice for one access.
// Assumes the address is a full physical address; any bit at or above
// bit 20 being set puts it outside the legacy hole.
module legacy_route
    import legacy_dec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int N_SEG  = 12
) (
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                acc_write,
    input  logic                smm_active,
    input  attr_t               high_attr,
    input  attr_t [N_SEG-1:0]   seg_attr,
    input  logic                smram_open,
    input  logic                smram_smm_en,
    output route_t              route
);

    logic [PAGE_W-1:0] page;
    logic              hi_clear;
    logic              in_win;
    logic              in_seg;
    logic              in_high;
    attr_t             seg_pick;

    // Classify the address into window, segment band, top range or outside.
    always_comb begin
        page     = acc_addr[HOLE_TOP-1:PAGE_SHIFT];
        hi_clear = (acc_addr[ADDR_W-1:HOLE_TOP] == '0);
        in_win   = hi_clear && (page >= PAGE_W'(WIN_FIRST)) && (page < PAGE_W'(SEG_FIRST));
        in_seg   = hi_clear && (page >= PAGE_W'(SEG_FIRST)) && (page < PAGE_W'(SEG_FIRST + N_SEG));
        in_high  = hi_clear && (page >= PAGE_W'(HIGH_FIRST));
    end

    // Select the attribute of the addressed segment.
    always_comb begin
        seg_pick = ATTR_OFF;
        for (int s = 0; s < N_SEG; s++) begin
            if (page == PAGE_W'(SEG_FIRST + s)) seg_pick = seg_attr[s];
        end
    end

    // Decide the destination; outside the hole neither is chosen.
    always_comb begin
        route = '0;
        if (in_win) begin
            route.dram = smram_open || (smm_active && smram_smm_en);
            route.bus  = !route.dram;
        end else if (in_seg) begin
            route = attr_route(seg_pick, acc_write);
        end else if (in_high) begin
            route = attr_route(high_attr, acc_write);
        end
    end

endmodule

// File: rtl/legacy_mem_decoder.sv
// Top of the legacy memory attribute and SMRAM decoder.
// Each valid access yields a one-cycle strobe on dram_sel or bus_fwd on
// the next cycle. The decode uses configuration state from before the
// edge and the management-mode flag from the access cycle.
module legacy_mem_decoder
    import legacy_dec_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          CFG_AW    = 8,
    parameter int          N_SEG     = 12,
    parameter logic [7:0]  ATTR_BASE = 8'h59,
    parameter logic [7:0]  SMRAM_OFS = 8'h72,
    parameter logic [7:0]  SMRAM_RST = 8'h02
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [7:0]          cfg_wdata,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic                acc_write,
    input  logic                smm_active,
    output logic                dram_sel,
    output logic                bus_fwd
);

    localparam int N_REGS = 1 + (N_SEG + 1) / 2;

    logic [N_REGS-1:0][1:0] fld_lo;
    logic [N_REGS-1:0][1:0] fld_hi;
    logic                   smram_open;
    logic                   smram_smm_en;
    attr_t                  high_attr;
    attr_t [N_SEG-1:0]      seg_attr;
    route_t                 route;

    legacy_cfg_regs #(
        .N_SEG(N_SEG), .CFG_AW(CFG_AW), .ATTR_BASE(ATTR_BASE),
        .SMRAM_OFS(SMRAM_OFS), .SMRAM_RST(SMRAM_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .fld_lo(fld_lo), .fld_hi(fld_hi),
        .smram_open(smram_open), .smram_smm_en(smram_smm_en)
    );

    legacy_seg_map #(.N_SEG(N_SEG)) u_map (
        .fld_lo(fld_lo), .fld_hi(fld_hi),
        .high_attr(high_attr), .seg_attr(seg_attr)
    );

    legacy_route #(.ADDR_W(ADDR_W), .N_SEG(N_SEG)) u_route (
        .acc_addr(acc_addr), .acc_write(acc_write), .smm_active(smm_active),
        .high_attr(high_attr), .seg_attr(seg_attr),
        .smram_open(smram_open), .smram_smm_en(smram_smm_en), .route(route)
    );

    // Register the destination strobes for one cycle per valid access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_sel <= 1'b0;
            bus_fwd  <= 1'b0;
        end else begin
            dram_sel <= acc_valid && route.dram;
            bus_fwd  <= acc_valid && route.bus;
        end
    end

endmodule

// File: rtl/legacy_dec_chk.sv
// Property checker for legacy_mem_decoder, attached by bind.
// Observes the ports and the SMRAM control bits held in the register block.
module legacy_dec_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              smm_active,
    input logic              smram_open,
    input logic              smram_smm_en,
    input logic              dram_sel,
    input logic              bus_fwd
);

    logic in_hole;
    logic in_win;
    assign in_hole = (acc_addr >= ADDR_W'(32'h000A_0000)) && (acc_addr < ADDR_W'(32'h0010_0000));
    assign in_win  = (acc_addr >= ADDR_W'(32'h000A_0000)) && (acc_addr < ADDR_W'(32'h000C_0000));

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_sel && bus_fwd));

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(acc_valid) |-> !dram_sel && !bus_fwd);

    // R6
    one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_hole |=> (dram_sel != bus_fwd));

    // R7
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !in_hole |=> !dram_sel && !bus_fwd);

    // R5
    win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && (smram_open || (smm_active && smram_smm_en)) |=> dram_sel);

    // R5
    win_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && in_win && !smram_open && !(smm_active && smram_smm_en) |=> bus_fwd);

endmodule

bind legacy_mem_decoder legacy_dec_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .smm_active(smm_active), .smram_open(smram_open), .smram_smm_en(smram_smm_en),
    .dram_sel(dram_sel), .bus_fwd(bus_fwd)
);

// File: tb/sim_legacy_mem_decoder.sv
`timescale 1ns/1ps
module sim_legacy_mem_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        acc_write = 1'b0;
    logic        smm_active = 1'b0;
    logic        dram_sel;
    logic        bus_fwd;

    int total = 0;
    int bad = 0;

    logic [7:0] m_attr [7];
    logic [7:0] m_smram;

    always #2.5 clk = ~clk;

    legacy_mem_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .smm_active(smm_active),
        .dram_sel(dram_sel), .bus_fwd(bus_fwd)
    );

    // Expected {dram, bus} from the bench copy of the written bytes.
    function automatic logic [1:0] expect_route(logic [31:0] a, logic wr, logic smm);
        logic [1:0] at;
        logic [7:0] b;
        int         seg;
        logic       d;
        if (a < 32'hA0000 || a >= 32'h100000) return 2'b00;
        if (a < 32'hC0000) begin
            d = m_smram[6] | (smm & m_smram[3]);
            return {d, !d};
        end
        if (a >= 32'hF0000) at = m_attr[0][5:4];
        else begin
            seg = int'((a - 32'hC0000) >> 14);
            b   = m_attr[1 + seg / 2];
            at  = (seg % 2 == 1) ? b[5:4] : b[1:0];
        end
        d = wr ? (at == 2'd3) : (at == 2'd1 || at == 2'd3);
        return {d, !d};
    endfunction

    task automatic judge(string tag, logic [1:0] got, logic [1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: {dram,bus} got=%b expected=%b addr=%h wr=%b smm=%b",
                     tag, got, exp, acc_addr, acc_write, smm_active);
        end
    endtask

    task automatic cfg_write(logic [7:0] ofs, logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ofs >= 8'h59 && ofs <= 8'h5F) m_attr[ofs - 8'h59] = val;
        if (ofs == 8'h72) m_smram = val;
    endtask

    task automatic access(string tag, logic [31:0] a, logic wr, logic smm);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr; smm_active = smm;
        @(negedge clk);
        judge(tag, {dram_sel, bus_fwd}, expect_route(a, wr, smm));
        acc_valid = 1'b0;
    endtask

    // Probe every 16 KB page of the hole with both directions and both SMM states.
    task automatic sweep(string tag);
        for (int p = 0; p < 24; p++) begin
            for (int m = 0; m < 4; m++) begin
                access(tag, 32'hA0000 + 32'(p) * 32'h4000 + ((32'(p) * 32'h123) & 32'h3FFF),
                       m[0], m[1]);
            end
        end
    endtask

    initial begin : watchdog
        #(5ns * 150000);
        bad++; total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 7; k++) m_attr[k] = 8'h00;
        m_smram = 8'h02;
        repeat (3) @(negedge clk);
        // R1: strobes low during reset
        judge("R1", {dram_sel, bus_fwd}, 2'b00);
        rst_n = 1'b1;
        // R1: reset configuration forwards the whole hole
        sweep("R1");
        // R2: top range from bits [5:4] of 0x59, all four codes
        for (int v = 0; v < 4; v++) begin
            cfg_write(8'h59, 8'(v << 4) | 8'h03);
            sweep("R2 R4");
        end
        cfg_write(8'h59, 8'h00);
        // R3: distinct field per segment, with junk in bits [3:2] and [7:6] (R8)
        for (int k = 0; k < 6; k++)
            cfg_write(8'(8'h5A + k), 8'(((k + 1) % 4) << 4) | 8'(k % 4) | 8'hCC);
        sweep("R3 R8");
        for (int k = 0; k < 6; k++)
            cfg_write(8'(8'h5A + k), 8'(((k + 3) % 4) << 4) | 8'((k + 2) % 4));
        sweep("R3");
        // R4: uniform codes over all ranges
        for (int v = 0; v < 4; v++) begin
            for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'(v * 8'h11));
            sweep("R4");
        end
        // R5: SMRAM control combinations
        cfg_write(8'h72, 8'h40); sweep("R5");
        cfg_write(8'h72, 8'h08); sweep("R5");
        cfg_write(8'h72, 8'h48); sweep("R5");
        cfg_write(8'h72, 8'hB7); sweep("R5");
        // R8: writes to neighbouring offsets have no effect
        cfg_write(8'h72, 8'h08);
        for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'h00);
        cfg_write(8'h58, 8'hFF); cfg_write(8'h60, 8'hFF);
        cfg_write(8'h71, 8'hFF); cfg_write(8'h73, 8'hFF);
        cfg_write(8'h00, 8'hFF); cfg_write(8'hFF, 8'hFF);
        sweep("R8");
        // R7: outside the hole, including aliases in the low 20 bits
        cfg_write(8'h72, 8'h40);
        for (int k = 0; k < 7; k++) cfg_write(8'(8'h59 + k), 8'h33);
        access("R7", 32'h0009_FFFF, 1'b0, 1'b0);
        access("R7", 32'h0000_0000, 1'b1, 1'b1);
        access("R7", 32'h0010_0000, 1'b0, 1'b0);
        access("R7", 32'h100A_0000, 1'b0, 1'b1);
        access("R7", 32'h001F_0000, 1'b1, 1'b0);
        access("R7", 32'hFFFF_FFFF, 1'b0, 1'b0);
        // R7 boundaries just inside
        access("R7", 32'h000A_0000, 1'b0, 1'b0);
        access("R7", 32'h000F_FFFF, 1'b1, 1'b0);
        // R9: SMRAM write and window access in the same cycle
        cfg_write(8'h72, 8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h72; cfg_wdata = 8'h40;
        acc_valid = 1'b1; acc_addr = 32'hA8000; acc_write = 1'b0; smm_active = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        judge("R9 old window route", {dram_sel, bus_fwd}, 2'b01);
        @(negedge clk);
        judge("R9 new window route", {dram_sel, bus_fwd}, 2'b10);
        acc_valid = 1'b0;
        m_smram = 8'h40;
        // R9: segment attribute write and segment write access in the same cycle
        cfg_write(8'h5A, 8'h00);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h5A; cfg_wdata = 8'h03;
        acc_valid = 1'b1; acc_addr = 32'hC1000; acc_write = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        judge("R9 old segment route", {dram_sel, bus_fwd}, 2'b01);
        @(negedge clk);
        judge("R9 new segment route", {dram_sel, bus_fwd}, 2'b10);
        acc_valid = 1'b0;
        m_attr[1] = 8'h03;
        // R6: a cycle without an access leaves both strobes low
        @(negedge clk);
        judge("R6 idle", {dram_sel, bus_fwd}, 2'b00);
        // R9: SMM flag applies in the access cycle
        cfg_write(8'h72, 8'h08);
        access("R9 smm", 32'hB0000, 1'b0, 1'b1);
        access("R9 smm", 32'hB0000, 1'b0, 1'b0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule